// File: doc/BRIEF.md
# Clear-on-read interrupt status controller

This block gathers interrupt events produced by a periodic monitoring loop into two status registers and turns them into one active-low interrupt line. A small stand-in sequencer counts a fixed number of clock cycles per loop pass. At the last cycle of each pass it ORs the two event input vectors into the status registers. Between passes the status registers only change when software reads them.

Software reaches the registers through a plain read/write strobe port. Reading a status register returns its contents and clears it in the same access. Two mask registers hold one bit per status bit, and a mask bit of 0 lets that status bit reach the line. A configuration register holds a line enable. It also holds a line-clear control that forces the line inactive and freezes the loop without disturbing the stored status.

Read results come back on `rd_data` with `rd_valid` one cycle after `rd_en`. There is no back-pressure: the consumer must take every result in the cycle it is valid.

Top module: `intstat_ctrl`

## Requirements
- R1: After reset both status registers, both mask registers and the configuration register read 0, and `irq_n` is 1.
- R2: Status bits are set only in the cycle `loop_done` is 1, when status becomes old status OR the event input. At any other time status changes only through a clearing read.
- R3: A read with `rd_en` returns the addressed register on `rd_data` with `rd_valid` one cycle later. The address map is: 0 is status 1, 1 is status 2, 2 is mask 1, 3 is mask 2 and 4 is configuration. A read of address 0 or 1 clears that status register.
- R4: A second read of a status register before the next loop pass returns 0, and after the clearing read `irq_n` returns to 1 until a later pass sets unmasked bits.
- R5: `irq_n` is 0 exactly when configuration bit 0 (line enable) is 1, configuration bit 3 is 0, and some status bit is 1 while its mask bit is 0. This includes status 2 bit 5, the over-temperature event, masked by mask 2 bit 5.
- R6: While configuration bit 3 (line-clear) is 1, `irq_n` is 1 and the status registers keep their contents.
- R7: While configuration bit 3 is 1 the loop does not advance and `loop_done` stays 0. The loop resumes when the bit returns to 0.
- R8: When a pass sets a status bit in the same cycle as a clearing read of that register, the bit stays set after the read.
- R9: With the line-clear bit at 0, `loop_done` pulses once every `LOOP_CYCLES` clock cycles.
- R10: Mask and configuration registers read back the last value written, and reading them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | DW | Read result |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_en` |
| ev1_in | input | DW | Events for status register 1 |
| ev2_in | input | DW | Events for status register 2 |
| loop_done | output | 1 | Pulse at the last cycle of each loop pass |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
The assertions check these rules on every cycle:
- the line-clear bit forcing the line high and stopping loop passes;
- status holding steady outside passes and clearing reads;
- a pass that coincides with a read still setting its bits;
- the loop period, measured in non-halted cycles;
- the read response latency.

Only the bench's scenarios can show the following:
- that the returned read values are right;
- that masks and the enable gate the line as specified, including the over-temperature bit;
- that status survives a halt;
- that the loop restarts once the halt is released.

// File: rtl/intstat_pkg.sv
package intstat_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] ADDR_ST1  = 3'd0;
  localparam logic [AW-1:0] ADDR_ST2  = 3'd1;
  localparam logic [AW-1:0] ADDR_MSK1 = 3'd2;
  localparam logic [AW-1:0] ADDR_MSK2 = 3'd3;
  localparam logic [AW-1:0] ADDR_CFG  = 3'd4;
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_LCLR_BIT = 3;
endpackage

// File: rtl/loop_seq.sv
module loop_seq #(
  parameter int LOOP_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  output logic pass
);
  localparam int CW = (LOOP_CYCLES > 2) ? $clog2(LOOP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOOP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign pass = (cnt_q == LAST) && !halt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!halt)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/stat_reg.sv
module stat_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [DW-1:0] set_vec,
  input  logic          clr,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (clr ? '0 : q) | (set_en ? set_vec : '0);
  end
endmodule

// File: rtl/intstat_ctrl.sv
module intstat_ctrl
  import intstat_pkg::*;
#(
  parameter int DW          = 8,
  parameter int LOOP_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic [DW-1:0] ev1_in,
  input  logic [DW-1:0] ev2_in,
  output logic          loop_done,
  output logic          irq_n
);
  localparam int NST = 2;

  logic [DW-1:0] cfg_q;
  logic [DW-1:0] msk_q [NST];
  logic [DW-1:0] st_q  [NST];
  logic [DW-1:0] ev    [NST];
  logic [NST-1:0] rd_clr;
  logic [NST-1:0] hit;
  logic [DW-1:0] st1_q, st2_q;
  logic          halt;

  assign halt  = cfg_q[CFG_LCLR_BIT];
  assign ev[0] = ev1_in;
  assign ev[1] = ev2_in;
  assign st1_q = st_q[0];
  assign st2_q = st_q[1];

  loop_seq #(.LOOP_CYCLES(LOOP_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .halt(halt), .pass(loop_done)
  );

  for (genvar g = 0; g < NST; g++) begin : g_st
    localparam logic [AW-1:0] ST_A  = AW'(g);
    localparam logic [AW-1:0] MSK_A = AW'(g + 2);
    assign rd_clr[g] = rd_en && (rd_addr == ST_A);
    assign hit[g]    = |(st_q[g] & ~msk_q[g]);

    stat_reg #(.DW(DW)) u_st (
      .clk(clk), .rst_n(rst_n), .set_en(loop_done), .set_vec(ev[g]),
      .clr(rd_clr[g]), .q(st_q[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)                            msk_q[g] <= '0;
      else if (wr_en && wr_addr == MSK_A)    msk_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              cfg_q <= '0;
    else if (wr_en && wr_addr == ADDR_CFG)   cfg_q <= wr_data;
  end

  assign irq_n = !(cfg_q[CFG_EN_BIT] && !halt && (|hit));

  logic [DW-1:0] rd_mux;
  always_comb begin
    unique case (rd_addr)
      ADDR_ST1:  rd_mux = st_q[0];
      ADDR_ST2:  rd_mux = st_q[1];
      ADDR_MSK1: rd_mux = msk_q[0];
      ADDR_MSK2: rd_mux = msk_q[1];
      ADDR_CFG:  rd_mux = cfg_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/intstat_chk.sv
module intstat_chk
  import intstat_pkg::*;
#(
  parameter int DW          = 8,
  parameter int LOOP_CYCLES = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          loop_done,
  input logic          irq_n,
  input logic [DW-1:0] cfg_q,
  input logic [DW-1:0] st1_q,
  input logic [DW-1:0] st2_q,
  input logic [DW-1:0] ev1_in
);
  localparam int GW = $clog2(LOOP_CYCLES) + 1;
  logic [GW-1:0] gap_q;
  logic halted;
  assign halted = cfg_q[CFG_LCLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)         gap_q <= '0;
    else if (loop_done) gap_q <= '0;
    else if (!halted)   gap_q <= gap_q + 1'b1;
  end

  AST_LCLR_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> irq_n); // R6
  AST_HALT_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !loop_done); // R7
  AST_ST1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_done && !(rd_en && rd_addr == ADDR_ST1)) |=> $stable(st1_q)); // R2
  AST_ST2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_done && !(rd_en && rd_addr == ADDR_ST2)) |=> $stable(st2_q)); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_ST1 && !loop_done) |=> (st1_q == '0)); // R3
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |=> ((st1_q & $past(ev1_in)) == $past(ev1_in))); // R8
  AST_LOOP_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |-> (gap_q == GW'(LOOP_CYCLES - 1))); // R9
endmodule

bind intstat_ctrl intstat_chk #(.DW(DW), .LOOP_CYCLES(LOOP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .loop_done(loop_done), .irq_n(irq_n),
  .cfg_q(cfg_q), .st1_q(st1_q), .st2_q(st2_q), .ev1_in(ev1_in)
);

// File: tb/tb_intstat_ctrl.sv
module tb_intstat_ctrl;
  localparam int DW = 8;
  localparam int LOOP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, ev1 = '0, ev2 = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, loop_done, irq_n;

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  intstat_ctrl #(.DW(DW), .LOOP_CYCLES(LOOP)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .ev1_in(ev1), .ev2_in(ev2), .loop_done(loop_done), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data as results appear
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check("R3 unexpected rd_valid", 1, 0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  // called at a negedge; returns at the next negedge
  task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string tag);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_pass();
    do @(negedge clk); while (!loop_done);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check("watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq_n after reset", irq_n, 1);
    rd(3'd0, 8'h00, "R1 st1 reset");
    rd(3'd1, 8'h00, "R1 st2 reset");
    rd(3'd2, 8'h00, "R1 msk1 reset");
    rd(3'd3, 8'h00, "R1 msk2 reset");
    rd(3'd4, 8'h00, "R1 cfg reset");

    // R9 period
    wait_pass();
    n = 0;
    do begin @(negedge clk); n++; end while (!loop_done);
    check("R9 loop period", n, LOOP);

    // R10 readback
    wr(3'd2, 8'hA5);
    rd(3'd2, 8'hA5, "R10 msk1 readback");
    rd(3'd2, 8'hA5, "R10 msk1 readback again");
    wr(3'd2, 8'h00);
    wr(3'd4, 8'h01);

    // R2 / R3 / R4 / R5
    wait_pass(); @(negedge clk);
    ev1 = 8'h05;
    rd(3'd0, 8'h00, "R2 no set before pass");
    check("R5 idle line", irq_n, 1);
    wait_pass(); @(negedge clk);
    ev1 = 8'h00;
    check("R5 line asserted", irq_n, 0);
    rd(3'd0, 8'h05, "R3 read st1");
    check("R4 line released after read", irq_n, 1);
    rd(3'd0, 8'h00, "R4 second read cleared");

    // R5 over-temperature bit 5 of status 2 with mask 2 bit 5
    wr(3'd3, 8'h20);
    wait_pass(); @(negedge clk);
    ev2 = 8'h20;
    wait_pass(); @(negedge clk);
    ev2 = 8'h00;
    check("R5 masked overtemp", irq_n, 1);
    wr(3'd3, 8'h00);
    check("R5 unmasked overtemp", irq_n, 0);
    wr(3'd4, 8'h00);
    check("R5 line disabled", irq_n, 1);
    wr(3'd4, 8'h01);
    rd(3'd1, 8'h20, "R5 st2 overtemp");

    // R6 / R7 line-clear halts loop
    wait_pass(); @(negedge clk);
    ev1 = 8'h03;
    wait_pass(); @(negedge clk);
    ev1 = 8'h00;
    check("R5 pending before line-clear", irq_n, 0);
    wr(3'd4, 8'h09);
    check("R6 line forced high", irq_n, 1);
    n = 0;
    repeat (3 * LOOP) begin @(negedge clk); if (loop_done) n++; end
    check("R7 no pass while halted", n, 0);
    rd(3'd0, 8'h03, "R6 status kept");
    ev1 = 8'h40;
    wr(3'd4, 8'h01);
    n = 0;
    while (!loop_done && n < 2 * LOOP) begin @(negedge clk); n++; end
    check("R7 loop resumes", (n < LOOP) ? 1 : 0, 1);
    @(negedge clk);
    ev1 = 8'h00;
    rd(3'd0, 8'h40, "R7 status after resume");

    // R8 set and clear in the same cycle
    ev1 = 8'h81;
    wait_pass();
    rd(3'd0, 8'h00, "R8 read at pass returns old");
    ev1 = 8'h00;
    rd(3'd0, 8'h81, "R8 set bits kept");

    repeat (3) @(negedge clk);
    check("R3 all reads answered", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule